// File: doc/BRIEF.md
# Dual-Plane Shadow Context Register Array

This block holds the flip-flop state of one column of reconfigurable logic in two copies. One copy, the active plane, is loaded from the user logic on every clock and drives the user-facing outputs. The other copy, the hidden plane, forms a serial scan chain. Because the two planes are separate, the context of the next task can be shifted into the hidden plane while the current task keeps running. In the same cycles, the context left by an earlier task can be shifted out of that chain.

A swap command makes the hidden plane the active plane, and the active plane the hidden one, in a single clock. The cost of a task switch is therefore one cycle for any array width. After the swap, the outgoing task's state sits in the hidden plane and can be scanned out while the new task runs. Swapping back and forth without scanning gives checkpointing, or time-sharing between two instances of one task.

Swap is accepted only at a shift boundary, that is, when the number of scan cycles taken so far is a whole multiple of the width. A shift still in progress therefore cannot be cut in half by a swap.

Top module: `shadow_ctx_array`

## Requirements
- R1: While reset is high, both planes are cleared and plane 0 is made active. During and right after reset, `user_q` is 0, `scan_out` is 0 and `swap_ready` is 1.
- R2: On every clock without an accepted swap, the active plane captures `user_d`, so `user_q` equals the previous cycle's `user_d`.
- R3: When `scan_en` is high and no swap is accepted, the hidden plane shifts one position toward its MSB and `scan_in` enters bit 0. `scan_out` always shows the hidden plane's MSB. When `scan_en` is low, the hidden plane holds its value.
- R4: A full context transfer takes exactly N scan cycles, with the MSB first on both ends. The new context enters at `scan_in` while the old context leaves at `scan_out` during the same N cycles.
- R5: `swap_ready` is 1 only when the count of scan cycles since reset is a multiple of N. It drops for the N-1 cycles between the first and the last bit of a shift.
- R6: A `swap_req` given while `swap_ready` is 0 has no effect. The planes keep their roles, and `user_q` still follows `user_d`.
- R7: A `swap_req` given while `swap_ready` is 1 exchanges the planes at that clock edge. From the next cycle, `user_q` shows the context that was in the hidden plane.
- R8: At the swap edge, the outgoing plane captures `user_d` one last time. That value then leaves at `scan_out`, MSB first, over the next N scan cycles.
- R9: In the cycle of an accepted swap, `scan_en` is ignored. No bit shifts, and the scan count does not advance, so `swap_ready` stays 1.
- R10: Two swaps with no scanning between them return the first context to the active plane, as it was captured at the first swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| user_d | input | N | Next-state bits from the user logic |
| user_q | output | N | Current active-plane bits to the user logic |
| scan_en | input | 1 | Shift the hidden plane one bit |
| scan_in | input | 1 | Serial bit entering hidden bit 0 |
| scan_out | output | 1 | Hidden plane MSB |
| swap_req | input | 1 | Request to exchange the planes |
| swap_ready | output | 1 | High when a swap would be accepted |

## Verification
The active plane is tested with a changing `user_d` stream while the hidden chain is idle and while it is shifting. This separates the capture path from the scan path. A known context is then shifted in, and a swap request is placed in the middle of that shift. This shows whether requests are gated at shift boundaries. Next, a swap is issued together with an active `scan_en`, followed by a full scan-out of a distinct word. This tests three things: that the swap takes one cycle, that the last captured word is exported in the right bit order, and that the swap cycle suppresses shifting. A final pair of back-to-back swaps without scanning tests that a checkpointed context comes back unchanged.

// File: rtl/shadow_ctx_pkg.sv
package shadow_ctx_pkg;

    typedef enum logic [1:0] {
        PL_HOLD    = 2'd0,
        PL_CAPTURE = 2'd1,
        PL_SHIFT   = 2'd2
    } plane_mode_e;

    function automatic int wrap_next(input int cur, input int limit);
        return (cur >= limit - 1) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/ctx_plane.sv
module ctx_plane
    import shadow_ctx_pkg::*;
#(
    parameter int N = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  plane_mode_e      mode,
    input  logic [N-1:0]     d,
    input  logic             sin,
    output logic [N-1:0]     q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (mode)
                PL_CAPTURE: q <= d;
                PL_SHIFT:   q <= {q[N-2:0], sin};
                default:    q <= q;
            endcase
        end
    end
endmodule

// File: rtl/ctx_swap_ctrl.sv
module ctx_swap_ctrl
    import shadow_ctx_pkg::*;
#(
    parameter int N = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic scan_en,
    input  logic swap_req,
    output logic swap_ready,
    output logic swap_fire,
    output logic act_sel
);
    localparam int CW = (N > 2) ? $clog2(N) : 1;

    logic [CW-1:0] shift_cnt;

    assign swap_ready = (shift_cnt == '0);
    assign swap_fire  = swap_req && swap_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_cnt <= '0;
            act_sel   <= 1'b0;
        end else begin
            if (swap_fire) begin
                act_sel <= ~act_sel;
            end else if (scan_en) begin
                shift_cnt <= CW'(wrap_next(int'(shift_cnt), N));
            end
        end
    end
endmodule

// File: rtl/shadow_ctx_array.sv
module shadow_ctx_array
    import shadow_ctx_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] user_d,
    output logic [N-1:0] user_q,
    input  logic         scan_en,
    input  logic         scan_in,
    output logic         scan_out,
    input  logic         swap_req,
    output logic         swap_ready
);
    localparam int PLANES = 2;

    logic         swap_fire;
    logic         act_sel;
    logic [N-1:0] plane_q [PLANES];
    plane_mode_e  plane_mode [PLANES];
    logic [N-1:0] hidden_q;

    ctx_swap_ctrl #(.N(N)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .scan_en    (scan_en),
        .swap_req   (swap_req),
        .swap_ready (swap_ready),
        .swap_fire  (swap_fire),
        .act_sel    (act_sel)
    );

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        always_comb begin
            if (act_sel == 1'(p))
                plane_mode[p] = PL_CAPTURE;
            else if (scan_en && !swap_fire)
                plane_mode[p] = PL_SHIFT;
            else
                plane_mode[p] = PL_HOLD;
        end

        ctx_plane #(.N(N)) u_plane (
            .clk  (clk),
            .rst  (rst),
            .mode (plane_mode[p]),
            .d    (user_d),
            .sin  (scan_in),
            .q    (plane_q[p])
        );
    end

    assign user_q   = act_sel ? plane_q[1] : plane_q[0];
    assign hidden_q = act_sel ? plane_q[0] : plane_q[1];
    assign scan_out = hidden_q[N-1];
endmodule

// File: rtl/shadow_ctx_array_chk.sv
module shadow_ctx_array_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] user_d,
    input logic [N-1:0] user_q,
    input logic         scan_en,
    input logic         scan_out,
    input logic         swap_req,
    input logic         swap_ready
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (swap_ready && user_q == '0 && !scan_out));

    // R2
    active_capture_chk: assert property (@(posedge clk) disable iff (rst)
        !(swap_req && swap_ready) |=> user_q == $past(user_d));

    // R3
    hidden_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && !(swap_req && swap_ready)) |=> $stable(scan_out));

    // R5
    mid_shift_block_chk: assert property (@(posedge clk) disable iff (rst)
        (scan_en && swap_ready && !swap_req) |=> !swap_ready);

    // R6
    blocked_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (swap_req && !swap_ready) |=> (!swap_ready || user_q == $past(user_d)));

    // R9
    swap_no_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (swap_req && swap_ready) |=> swap_ready);
endmodule

bind shadow_ctx_array shadow_ctx_array_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .user_d     (user_d),
    .user_q     (user_q),
    .scan_en    (scan_en),
    .scan_out   (scan_out),
    .swap_req   (swap_req),
    .swap_ready (swap_ready)
);

// File: tb/test_shadow_ctx_array.sv
module test_shadow_ctx_array;
    localparam int N = 16;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] user_d;
    logic [N-1:0] user_q;
    logic         scan_en;
    logic         scan_in;
    logic         scan_out;
    logic         swap_req;
    logic         swap_ready;

    int checks = 0;
    int fails  = 0;

    // behavioural reference
    logic [N-1:0] m_plane [2];
    bit           m_sel;
    int           m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    shadow_ctx_array #(.N(N)) i_shadow_ctx_array (
        .clk(clk), .rst(rst), .user_d(user_d), .user_q(user_q),
        .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out),
        .swap_req(swap_req), .swap_ready(swap_ready)
    );

    task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        bit fire;
        if (rst) begin
            m_plane[0] = '0; m_plane[1] = '0; m_sel = 0; m_cnt = 0;
        end else begin
            fire = swap_req && (m_cnt == 0);
            if (scan_en && !fire)
                m_plane[!m_sel] = {m_plane[!m_sel][N-2:0], scan_in};
            m_plane[m_sel] = user_d;
            if (fire) m_sel = !m_sel;
            else if (scan_en) m_cnt = (m_cnt + 1) % N;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(user_q === m_plane[m_sel], "R2 active plane", user_q, m_plane[m_sel]);
        chk(scan_out === m_plane[!m_sel][N-1], "R3 scan_out", N'(scan_out), N'(m_plane[!m_sel][N-1]));
        chk(swap_ready === (m_cnt == 0), "R5 swap_ready", N'(swap_ready), N'(m_cnt == 0));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        logic [N-1:0] ctx_a = 16'hA5C3;
        logic [N-1:0] ctx_b = 16'h5E0F;
        logic [N-1:0] got;
        logic [N-1:0] held_d;

        rst = 1; user_d = '0; scan_en = 0; scan_in = 0; swap_req = 0;
        tick(); tick();
        chk(user_q === '0, "R1 user_q reset", user_q, '0);
        chk(scan_out === 1'b0, "R1 scan_out reset", N'(scan_out), '0);
        chk(swap_ready === 1'b1, "R1 swap_ready reset", N'(swap_ready), N'(1));
        rst = 0;

        for (int i = 0; i < 6; i++) begin
            user_d = N'(i * 37 + 5);
            tick();
        end

        // R4: shift ctx_a in, MSB first, while user logic runs
        for (int i = 0; i < N; i++) begin
            scan_en = 1; scan_in = ctx_a[N-1-i]; user_d = N'(i * 11 + 3);
            if (i == 6) begin
                chk(swap_ready === 1'b0, "R5 mid-shift not ready", N'(swap_ready), '0);
                swap_req = 1; held_d = user_d;
                tick();
                swap_req = 0;
                chk(user_q === held_d, "R6 blocked swap ignored", user_q, held_d);
            end else begin
                tick();
            end
        end
        scan_en = 0;
        chk(swap_ready === 1'b1, "R4 ready after N cycles", N'(swap_ready), N'(1));

        // R7/R9: swap with scan_en asserted
        user_d = 16'h1234; swap_req = 1; scan_en = 1; scan_in = 1;
        tick();
        swap_req = 0; scan_en = 0;
        chk(user_q === ctx_a, "R7 swapped context active", user_q, ctx_a);
        chk(swap_ready === 1'b1, "R9 count not advanced", N'(swap_ready), N'(1));

        // R8/R4: shift out old context while shifting ctx_b in
        got = '0;
        for (int i = 0; i < N; i++) begin
            got = {got[N-2:0], scan_out};
            scan_en = 1; scan_in = ctx_b[N-1-i]; user_d = N'(i * 5 + 9);
            tick();
        end
        scan_en = 0;
        chk(got === 16'h1234, "R8 outgoing context scanned out", got, 16'h1234);

        // R10: checkpoint by double swap
        user_d = 16'h0F0F; swap_req = 1;
        tick();
        chk(user_q === ctx_b, "R10 first swap", user_q, ctx_b);
        user_d = 16'h7777;
        tick();
        swap_req = 0;
        chk(user_q === 16'h0F0F, "R10 context returned", user_q, 16'h0F0F);
        tick(); tick();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule